// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the shifting core of a SPI master. Software, or a sequencer in front of it, loads bytes into a 64-entry transmit FIFO, sets the clock mode, the slave index and the select polarity, writes a burst length and a transmit length, and pulses an exchange request. The engine asserts the chosen slave select and clocks out the whole burst full duplex. Every received byte goes into a 64-entry receive FIFO. When the last byte has been shifted, the engine releases the select and raises a one-cycle completion pulse.

The SCLK timebase comes from outside. Each `sclk_tick` pulse marks one half-period of SCLK, so an external divider sets the bit rate. The burst length and the transmit length are independent. Bytes beyond the transmit length are sent as zeros, which makes read-only tails possible. If the transmit FIFO runs dry while bytes are still owed, the engine flags an underrun. If the receive FIFO is full when a byte completes, the engine flags an overflow.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, `xch_busy` is low, both FIFO levels are 0, no event pulse is raised, every `spi_ss` line is at its inactive level, and `spi_sclk` equals `cfg_cpol`.
- R2: Each FIFO holds up to 64 bytes. An accepted push raises its level by one and an accepted pop lowers it by one. A push into a full transmit FIFO is ignored, and a level never exceeds 64.
- R3: A received byte that completes while the receive FIFO holds 64 entries is discarded. `rx_overflow` pulses for one cycle, and the level stays at 64 with the stored bytes unchanged.
- R4: A pulse on `tx_flush` or `rx_flush` empties that FIFO, and its level reads 0 on the next cycle.
- R5: `xch_req` starts a burst only when the engine is idle, `cfg_enable` is 1 and `burst_len` is nonzero. `xch_busy` then rises on the next cycle and falls by itself at the end of the burst. A request made while busy, while disabled or with a zero length has no effect.
- R6: SCLK rests at `cfg_cpol`. With `cfg_cpha`=0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With `cfg_cpha`=1, the roles of the two edges swap. Bytes are sent most significant bit first, and every byte of the burst is received into the receive FIFO.
- R7: The first min(`tx_len`, `burst_len`) bytes are taken from the transmit FIFO in order. The remaining bytes of the burst go out as 0x00 without popping the FIFO.
- R8: When a byte is owed from the transmit FIFO and the FIFO is empty, 0x00 is sent and `tx_underrun` pulses for one cycle. This happens once for each such byte.
- R9: During a burst only `spi_ss[cfg_ss_sel]` is active. The active level is high when `cfg_ss_high`=1 and low when it is 0. The select is asserted at least one tick interval before the first SCLK edge and released exactly one tick interval after the last edge, and SCLK does not toggle while the select is inactive.
- R10: A burst of N bytes produces exactly 16·N SCLK edges. `xfer_done` pulses once, in the same cycle that `xch_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_tick | input | 1 | Half-SCLK-period enable from the external divider |
| cfg_enable | input | 1 | Allows a burst to start |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_ss_high | input | 1 | Select active level (1 = high) |
| cfg_ss_sel | input | SEL_W | Index of the slave select to drive |
| tx_flush | input | 1 | Empties the transmit FIFO |
| rx_flush | input | 1 | Empties the receive FIFO |
| xch_req | input | 1 | Exchange request pulse |
| burst_len | input | CNT_W | Bytes in the burst |
| tx_len | input | CNT_W | Bytes taken from the transmit FIFO |
| tx_push | input | 1 | Write strobe for the transmit FIFO |
| tx_wdata | input | 8 | Byte to push |
| rx_pop | input | 1 | Read strobe for the receive FIFO |
| rx_rdata | output | 8 | Head byte of the receive FIFO |
| tx_level | output | LVL_W | Transmit FIFO fill count |
| rx_level | output | LVL_W | Receive FIFO fill count |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_ss | output | NUM_SS | Slave selects |
| xch_busy | output | 1 | Exchange in progress; clears itself at burst end |
| xfer_done | output | 1 | One-cycle burst-complete pulse |
| tx_underrun | output | 1 | One-cycle pulse for a byte sent as zero with the FIFO empty |
| rx_overflow | output | 1 | One-cycle pulse for a received byte dropped with the FIFO full |

## Verification
A stale byte counter shows up in two ways: as a wrong number of SCLK edges, and as `xfer_done` arriving early or late by a whole byte time (64 core cycles with a divide-by-four tick). The bench counts edges exactly. A misaligned bit phase corrupts the first byte captured from MOSI and the first byte popped from the receive FIFO, in every one of the four modes. An owed-byte count that is off by one puts a FIFO byte where a zero belongs, and it also leaves the transmit level wrong once the burst is done. Select timing is measured in core cycles against the tick interval, so a premature release or a late assertion shows up within a single half-period.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_SHIFT, PH_TRAIL} phase_e;

  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned EDGES_PER_BYTE = 2 * BYTE_W;
  localparam int unsigned EDGE_W         = $clog2(EDGES_PER_BYTE);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES_PER_BYTE - 1);

  // Leading edges carry an even number within a byte.
  function automatic logic f_is_sample(input logic cpha, input logic [EDGE_W-1:0] edge_no);
    return edge_no[0] == cpha;
  endfunction

  // The first bit is preloaded and the last edge reloads, so neither shifts.
  function automatic logic f_is_shift(input logic cpha, input logic [EDGE_W-1:0] edge_no);
    return !f_is_sample(cpha, edge_no) && edge_no != '0 && edge_no != LAST_EDGE;
  endfunction

  function automatic logic [BYTE_W-1:0] f_next_tx(input logic owed, input logic empty,
                                                  input logic [BYTE_W-1:0] head);
    return (owed && !empty) ? head : '0;
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = level == LW'(DEPTH);
  assign empty   = level == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              xch,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic [BYTE_W-1:0] tx_head,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic [SEL_W-1:0]  cs_sel,
  output logic              done,
  output logic              underrun,
  output logic              start_ok,
  output logic              byte_end
);

  phase_e             phase;
  logic [EDGE_W-1:0]  edge_no;
  logic [CNT_W-1:0]   left, owed, owed_base;
  logic [BYTE_W-1:0]  tx_sr, rx_sr;
  logic               cpha_q, sclk_q, done_q, under_q;
  logic [SEL_W-1:0]   sel_q;
  logic               load_now, owe_now, sample_now, shift_now, last_byte, tick_shift;

  assign start_ok   = (phase == PH_IDLE) && xch && enable && (burst_len != '0);
  assign tick_shift = (phase == PH_SHIFT) && tick;
  assign byte_end   = tick_shift && (edge_no == LAST_EDGE);
  assign last_byte  = left == CNT_W'(1);
  assign load_now   = start_ok || (byte_end && !last_byte);
  assign owed_base  = start_ok ? tx_len : owed;
  assign owe_now    = owed_base != '0;
  assign tx_pop     = load_now && owe_now && !tx_empty;
  assign sample_now = tick_shift && f_is_sample(cpha_q, edge_no);
  assign shift_now  = tick_shift && f_is_shift(cpha_q, edge_no);
  assign rx_push    = byte_end;
  assign rx_byte    = cpha_q ? {rx_sr[BYTE_W-2:0], miso} : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      edge_no <= '0;
      left    <= '0;
      owed    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      under_q <= load_now && owe_now && tx_empty;
      if (load_now) begin
        tx_sr <= f_next_tx(owe_now, tx_empty, tx_head);
        owed  <= owe_now ? owed_base - 1'b1 : owed_base;
      end else if (shift_now) begin
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
      if (sample_now) rx_sr <= {rx_sr[BYTE_W-2:0], miso};
      case (phase)
        PH_IDLE: begin
          sclk_q <= cpol;
          if (start_ok) begin
            phase  <= PH_LEAD;
            left   <= burst_len;
            cpha_q <= cpha;
            sel_q  <= sel;
          end
        end
        PH_LEAD: if (tick) begin
          phase   <= PH_SHIFT;
          edge_no <= '0;
        end
        PH_SHIFT: if (tick) begin
          sclk_q  <= ~sclk_q;
          edge_no <= edge_no + 1'b1;
          if (edge_no == LAST_EDGE) begin
            left <= left - 1'b1;
            if (last_byte) phase <= PH_TRAIL;
          end
        end
        PH_TRAIL: if (tick) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign mosi     = tx_sr[BYTE_W-1];
  assign busy     = phase != PH_IDLE;
  assign cs_sel   = sel_q;
  assign done     = done_q;
  assign underrun = under_q;

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned NUM_SS     = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned SEL_W     = (NUM_SS > 1) ? $clog2(NUM_SS) : 1,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_tick,
  input  logic              cfg_enable,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_ss_high,
  input  logic [SEL_W-1:0]  cfg_ss_sel,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              xch_req,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tx_push,
  input  logic [7:0]        tx_wdata,
  input  logic              rx_pop,
  output logic [7:0]        rx_rdata,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  input  logic              spi_miso,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_SS-1:0] spi_ss,
  output logic              xch_busy,
  output logic              xfer_done,
  output logic              tx_underrun,
  output logic              rx_overflow
);

  logic [7:0]       tx_head, rx_byte;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic             tx_pop, rx_push;
  logic             eng_start, eng_byte_end;
  logic [SEL_W-1:0] cs_sel;
  logic             ovf_event, ovf_q;

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk, .rst_n, .flush(tx_flush), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk, .rst_n, .flush(rx_flush), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_rdata), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_shift_engine #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_engine (
    .clk, .rst_n, .tick(sclk_tick), .xch(xch_req), .enable(cfg_enable),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .sel(cfg_ss_sel),
    .burst_len, .tx_len, .tx_head, .tx_empty, .tx_pop, .rx_push, .rx_byte,
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(xch_busy),
    .cs_sel, .done(xfer_done), .underrun(tx_underrun),
    .start_ok(eng_start), .byte_end(eng_byte_end)
  );

  assign ovf_event = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_event;
  end
  assign rx_overflow = ovf_q;

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign spi_ss[i] = (xch_busy && cs_sel == SEL_W'(i)) ? cfg_ss_high : ~cfg_ss_high;
  end

endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
  parameter int unsigned NUM_SS = 4,
  parameter int unsigned LVL_W  = 7,
  parameter int unsigned DEPTH  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cpol,
  input logic              cfg_ss_high,
  input logic [NUM_SS-1:0] spi_ss,
  input logic              spi_sclk,
  input logic              xch_busy,
  input logic              xfer_done,
  input logic              tx_underrun,
  input logic              rx_overflow,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              start_ok
);

  logic [NUM_SS-1:0] act;
  assign act = cfg_ss_high ? spi_ss : ~spi_ss;

  // R2: fill level bounded by the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH));

  // R3: receive level bounded, and an overflow only follows a full FIFO
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(DEPTH));
  a_r3_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> $past(rx_level) == LVL_W'(DEPTH));

  // R5: busy rises only after an accepted request
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xch_busy) |-> $past(start_ok));

  // R6: SCLK rests at the configured polarity while idle
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !xch_busy && $past(!xch_busy) && $stable(cfg_cpol) |-> spi_sclk == cfg_cpol);

  // R8: an underrun is only reported inside a burst
  a_r8_underrun_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> xch_busy);

  // R9: at most one select active; exactly one around every SCLK toggle in a burst
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));
  a_r9_edge_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sclk) && xch_busy && $past(xch_busy) |-> $countones(act) == 1);

  // R10: completion coincides with busy falling
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !xch_busy && $past(xch_busy));

endmodule

bind spi_burst_master spi_burst_checker #(.NUM_SS(NUM_SS), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk, .rst_n, .cfg_cpol, .cfg_ss_high, .spi_ss, .spi_sclk, .xch_busy, .xfer_done,
  .tx_underrun, .rx_overflow, .tx_level, .rx_level, .start_ok(eng_start)
);

// File: tb/test_spi_burst_master.sv
`timescale 1ns/1ps
module test_spi_burst_master;
  localparam int DEPTH = 64;
  localparam int NSS   = 4;
  localparam int CW    = 16;
  localparam int TP    = 4;  // core cycles per sclk_tick (one half SCLK period)

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sclk_tick = 0, cfg_enable = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_ss_high = 0;
  logic [1:0] cfg_ss_sel = '0;
  logic tx_flush = 0, rx_flush = 0, xch_req = 0, tx_push = 0, rx_pop = 0, spi_miso = 0;
  logic [CW-1:0] burst_len = '0, tx_len = '0;
  logic [7:0] tx_wdata = '0, rx_rdata;
  logic [6:0] tx_level, rx_level;
  logic spi_sclk, spi_mosi, xch_busy, xfer_done, tx_underrun, rx_overflow;
  logic [NSS-1:0] spi_ss;

  spi_burst_master #(.FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .CNT_W(CW)) i_spi_burst_master (
    .clk, .rst_n, .sclk_tick, .cfg_enable, .cfg_cpol, .cfg_cpha, .cfg_ss_high, .cfg_ss_sel,
    .tx_flush, .rx_flush, .xch_req, .burst_len, .tx_len, .tx_push, .tx_wdata, .rx_pop,
    .rx_rdata, .tx_level, .rx_level, .spi_miso, .spi_sclk, .spi_mosi, .spi_ss,
    .xch_busy, .xfer_done, .tx_underrun, .rx_overflow
  );

  int total = 0, bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor and slave model state
  logic m_cpol = 0, m_cpha = 0, m_high = 0;
  int   m_sel = 0;
  logic prev_sclk = 0, prev_mosi = 0, prev_cs = 0;
  int   cyc = 0, div = 0, edges = 0, mbits = 0, mcount = 0, sp = 0;
  int   dones = 0, unders = 0, overs = 0, viol = 0;
  int   cs_on_cyc = 0, cs_off_cyc = 0, first_edge_cyc = 0, last_edge_cyc = 0;
  logic [7:0] mosi_sr = '0;
  logic [7:0] mosi_bytes [128];
  logic [7:0] sl_bytes [128];

  function automatic logic slave_bit(input int s);
    if (s / 8 >= 128) return 1'b0;
    return sl_bytes[s / 8][7 - (s % 8)];
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      begin
        logic cs_now, lead;
        cyc++;
        cs_now = (spi_ss[m_sel] == m_high);
        for (int k = 0; k < NSS; k++)
          if (k != m_sel && spi_ss[k] == m_high) viol++;
        if (cs_now && !prev_cs) cs_on_cyc = cyc;
        if (!cs_now && prev_cs) cs_off_cyc = cyc;
        if (spi_sclk != prev_sclk && xch_busy) begin
          if (!cs_now) viol++;
          if (edges == 0) first_edge_cyc = cyc;
          last_edge_cyc = cyc;
          edges++;
          lead = (prev_sclk == m_cpol);
          if (lead != m_cpha) begin
            mosi_sr = {mosi_sr[6:0], prev_mosi};
            mbits++;
            if (mbits % 8 == 0 && mcount < 128) begin
              mosi_bytes[mcount] = mosi_sr;
              mcount++;
            end
          end else begin
            spi_miso = slave_bit(sp);
            sp++;
          end
        end
        if (xfer_done)   dones++;
        if (tx_underrun) unders++;
        if (rx_overflow) overs++;
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        prev_cs   = cs_now;
        div = (div + 1) % TP;
        sclk_tick = (div == 0);
      end
    end
  end

  task automatic setup(input logic cpol, input logic cpha, input int sel, input logic high);
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_ss_sel = 2'(sel); cfg_ss_high = high;
    m_cpol = cpol; m_cpha = cpha; m_sel = sel; m_high = high;
    repeat (2) @(negedge clk);
    edges = 0; mbits = 0; mcount = 0; dones = 0; unders = 0; overs = 0; viol = 0;
    sp = 0;
    if (!cpha) begin spi_miso = slave_bit(0); sp = 1; end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_wdata = b;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, "rx byte", int'(rx_rdata), int'(exp));
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic pulse_xch(input int n, input int txn);
    @(negedge clk); burst_len = CW'(n); tx_len = CW'(txn); xch_req = 1;
    @(negedge clk); xch_req = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!xch_busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic flush_both();
    @(negedge clk); tx_flush = 1; rx_flush = 1;
    @(negedge clk); tx_flush = 0; rx_flush = 0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1", "busy", int'(xch_busy), 0);
    chk("R1", "tx_level", int'(tx_level), 0);
    chk("R1", "rx_level", int'(rx_level), 0);
    chk("R1", "ss idle", int'(spi_ss), 4'hF);
    chk("R1", "sclk idle", int'(spi_sclk), 0);
    chk("R1", "pulses", int'({xfer_done, tx_underrun, rx_overflow}), 0);
  endtask

  task automatic t_fifo();
    for (int k = 0; k < 3; k++) push(8'(k));
    chk("R2", "level after 3 pushes", int'(tx_level), 3);
    for (int k = 0; k < 64; k++) push(8'(k));
    chk("R2", "level saturates", int'(tx_level), 64);
    @(negedge clk); tx_flush = 1;
    @(negedge clk); tx_flush = 0;
    chk("R4", "tx flush", int'(tx_level), 0);
  endtask

  task automatic t_mode(input int mode);
    logic [7:0] a, b;
    a = 8'h96 ^ 8'(mode * 17);
    b = 8'h3B ^ 8'(mode * 5);
    sl_bytes[0] = 8'hC5 ^ 8'(mode);
    sl_bytes[1] = 8'h5A ^ 8'(mode * 3);
    flush_both();
    setup(mode[1], mode[0], mode, mode[0]);
    push(a); push(b);
    pulse_xch(2, 2);
    wait_idle();
    chk("R6", "mosi byte0", int'(mosi_bytes[0]), int'(a));
    chk("R6", "mosi byte1", int'(mosi_bytes[1]), int'(b));
    chk("R6", "rx level", int'(rx_level), 2);
    pop_chk("R6", sl_bytes[0]);
    pop_chk("R6", sl_bytes[1]);
    chk("R6", "sclk rest", int'(spi_sclk), int'(mode[1]));
    chk("R7", "tx drained", int'(tx_level), 0);
    chk("R10", "edge count", edges, 32);
    chk("R10", "done pulses", dones, 1);
    chk("R9", "select violations", viol, 0);
    chk("R9", "lead >= half period", int'(first_edge_cyc - cs_on_cyc >= TP + 1), 1);
    chk("R9", "trail == half period", cs_off_cyc - last_edge_cyc, TP);
  endtask

  task automatic t_txlen();
    flush_both();
    setup(1'b0, 1'b0, 1, 1'b0);
    push(8'hA5); push(8'h3C); push(8'h7E);
    pulse_xch(2, 1);
    wait_idle();
    chk("R7", "first byte from fifo", int'(mosi_bytes[0]), 8'hA5);
    chk("R7", "tail byte zero", int'(mosi_bytes[1]), 0);
    chk("R7", "fifo keeps rest", int'(tx_level), 2);
    chk("R7", "no underrun", unders, 0);
    flush_both();
    setup(1'b0, 1'b0, 1, 1'b0);
    push(8'hC3);
    pulse_xch(3, 2);
    wait_idle();
    chk("R8", "byte0", int'(mosi_bytes[0]), 8'hC3);
    chk("R8", "underrun byte zero", int'(mosi_bytes[1]), 0);
    chk("R8", "byte2 zero", int'(mosi_bytes[2]), 0);
    chk("R8", "underrun pulses", unders, 1);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 65; k++) sl_bytes[k] = 8'(k * 7 + 1);
    flush_both();
    setup(1'b1, 1'b1, 3, 1'b1);
    pulse_xch(65, 0);
    wait_idle();
    chk("R3", "overflow pulses", overs, 1);
    chk("R3", "rx level held", int'(rx_level), 64);
    chk("R10", "edges 65 bytes", edges, 65 * 16);
    pop_chk("R3", sl_bytes[0]);
    @(negedge clk); rx_flush = 1;
    @(negedge clk); rx_flush = 0;
    chk("R4", "rx flush", int'(rx_level), 0);
  endtask

  task automatic t_start();
    flush_both();
    setup(1'b0, 1'b0, 2, 1'b1);
    cfg_enable = 0;
    pulse_xch(1, 0);
    repeat (3 * TP) @(negedge clk);
    chk("R5", "disabled ignored", int'(xch_busy), 0);
    chk("R5", "disabled no edges", edges, 0);
    cfg_enable = 1;
    pulse_xch(0, 0);
    repeat (3 * TP) @(negedge clk);
    chk("R5", "zero length ignored", int'(xch_busy) + edges, 0);
    @(negedge clk); burst_len = 1; tx_len = 0; xch_req = 1;
    @(negedge clk); xch_req = 0;
    chk("R5", "busy after start", int'(xch_busy), 1);
    repeat (20) @(negedge clk);
    pulse_xch(5, 0);
    wait_idle();
    repeat (10 * TP) @(negedge clk);
    chk("R5", "restart while busy ignored", edges, 16);
    chk("R10", "single done", dones, 1);
    chk("R5", "busy self-cleared", int'(xch_busy), 0);
    chk("R9", "select index 2 only", viol, 0);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    cfg_enable = 1;
    t_fifo();
    for (int m = 0; m < 4; m++) t_mode(m);
    t_txlen();
    t_overflow();
    t_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule